// File: doc/BRIEF.md
# Adaptive Timer Calibration Sequencer

This block is the digital sequencer that tunes an on-chip analog timer, or slow ramp generator, in discrete steps. Each iteration clears the integrator for one cycle, then opens an integrate window of an exact number of clock cycles. The window length is chosen so that a correctly tuned current ends on the reference voltage. After the window it reads an external comparator. The comparator reports whether the integrator's final voltage lies above or below that reference. The result moves a digital current-control code, which an external DAC converts into the reference current.

The code moves by a step that starts at a quarter of full scale and halves each time the comparator verdict flips direction. Once the step is down to one LSB and the verdict flips again, the code straddles the ideal value and the block raises `ready`. If that never happens within a set number of iterations, the block raises `calFail`. The code drives the master timer. A second copy of it feeds the slave timer, which takes real measurements. In slow-ramp mode the slave timer is idle, so its copy is frozen and the longer ramp window is used.

Top module: `timer_cal_seq`

## Requirements
- R1: After a start, each iteration drives `intReset` high for exactly one cycle. `intEnable` then goes high for exactly WIN consecutive cycles when the mode is timer mode (`monoMode`=0 at start). The two are never high together.
- R2: With `monoMode`=1 at start, every integrate window lasts MONO_WIN cycles instead. The mode is latched at start.
- R3: `cmpHigh`=1 at the end of a window (voltage above reference) lowers `ctrlCode`. `cmpHigh`=0 raises it.
- R4: A start loads `ctrlCode` with 2^(CODE_W-1) and the step with 2^(CODE_W-2). The step halves whenever the comparator direction differs from the previous iteration's, and the halved step is applied in that same update.
- R5: `ctrlCode` saturates at 0 and at 2^CODE_W-1 and never wraps.
- R6: When the direction flips while the step is 1, `ready` rises. The code is left unchanged, and `ready` holds until the next start.
- R7: If MAX_ITER iterations complete without convergence, `calFail` rises after exactly MAX_ITER `intReset` pulses and holds until the next start. `ready` and `calFail` are never high together.
- R8: In timer mode, `slaveCode` follows `ctrlCode`, including the load at start. In slow-ramp mode, `slaveCode` keeps the value it had before the start.
- R9: A `startCal` pulse while a calibration is in progress has no effect on the sequence or its result.
- R10: After reset, `ctrlCode` and `slaveCode` equal 2^(CODE_W-1). `ready`, `calFail`, `intEnable` and `intReset` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startCal | input | 1 | Starts a calibration when no run is in progress |
| monoMode | input | 1 | 1 selects slow-ramp mode, sampled at start |
| cmpHigh | input | 1 | Comparator: integrator final voltage above reference |
| intReset | output | 1 | Clears the external integrator |
| intEnable | output | 1 | Integrate window enable |
| ctrlCode | output | CODE_W | Current-control code for the master timer |
| slaveCode | output | CODE_W | Current-control code for the slave timer |
| ready | output | 1 | Calibration converged |
| calFail | output | 1 | Calibration did not converge within MAX_ITER |

## Verification
The assertions assume `cmpHigh` is steady through the sampling cycle after each window. They also assume it is a monotonic function of the code, as a real integrator and comparator would give. The bench models the analog side as an ideal comparator of the code against a target value. It updates `cmpHigh` only at falling edges, so the input is settled whenever the sequencer reads it. Sweeping every target across the code range covers both saturation ends, the convergence paths and the failure path, all within those assumptions.

// File: rtl/tcal_pkg.sv
package tcal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CLR, ST_INTEG, ST_SAMPLE, ST_DONE, ST_FAIL
  } calState_t;

  typedef struct packed {
    logic load;    // restart code and step
    logic update;  // apply comparator verdict
    logic mono;    // slow-ramp mode active
  } calStrobe_t;
endpackage

// File: rtl/tcal_datapath.sv
module tcal_datapath
  import tcal_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  calStrobe_t        stb,
  input  logic              cmpHigh,
  output logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] slaveCode,
  output logic              converged
);
  localparam logic [CODE_W-1:0] MidCode  = CODE_W'(1) << (CODE_W-1);
  localparam logic [CODE_W-1:0] InitStep = CODE_W'(1) << (CODE_W-2);
  localparam logic [CODE_W:0]   MaxCode  = (CODE_W+1)'((1 << CODE_W) - 1);

  logic [CODE_W-1:0] codeQ, slaveQ, stepQ, nextStep, newCode;
  logic [CODE_W:0]   upSum;
  logic              prevUp, havePrev, dirUp, flip;

  always_comb begin
    dirUp     = !cmpHigh;
    flip      = havePrev && (dirUp != prevUp);
    converged = flip && (stepQ == CODE_W'(1));
    nextStep  = flip ? (stepQ >> 1) : stepQ;
    upSum     = {1'b0, codeQ} + {1'b0, nextStep};
    if (dirUp)
      newCode = (upSum > MaxCode) ? MaxCode[CODE_W-1:0] : upSum[CODE_W-1:0];
    else
      newCode = (codeQ >= nextStep) ? (codeQ - nextStep) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeQ    <= MidCode;
      slaveQ   <= MidCode;
      stepQ    <= InitStep;
      prevUp   <= 1'b0;
      havePrev <= 1'b0;
    end else if (stb.load) begin
      codeQ    <= MidCode;
      stepQ    <= InitStep;
      prevUp   <= 1'b0;
      havePrev <= 1'b0;
      if (!stb.mono) slaveQ <= MidCode;
    end else if (stb.update && !converged) begin
      codeQ    <= newCode;
      stepQ    <= nextStep;
      prevUp   <= dirUp;
      havePrev <= 1'b1;
      if (!stb.mono) slaveQ <= newCode;
    end
  end

  assign code      = codeQ;
  assign slaveCode = slaveQ;

  // R4: step never collapses to zero
  p_step_nonzero_r4: assert property (@(posedge clk) disable iff (!rstN)
    stepQ != '0);
  // R3: a high verdict never raises the code
  p_high_lowers_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.update && cmpHigh && !stb.load) |=> codeQ <= $past(codeQ));
  // R5: an update moves the code by at most the old step (no wrap)
  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.update && !stb.load) |=>
      ((codeQ >= $past(codeQ)) ? (codeQ - $past(codeQ)) : ($past(codeQ) - codeQ))
        <= $past(stepQ));
  // R8: the slave copy is frozen in slow-ramp mode
  p_slave_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.mono |=> $stable(slaveQ));
  // R6: code is held outside load and update
  p_code_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.load && !stb.update) |=> $stable(codeQ));
endmodule

// File: rtl/tcal_ctrl.sv
module tcal_ctrl
  import tcal_pkg::*;
#(
  parameter int WIN      = 8,
  parameter int MONO_WIN = 24,
  parameter int MAX_ITER = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startCal,
  input  logic       monoMode,
  input  logic       converged,
  output calStrobe_t stb,
  output logic       intReset,
  output logic       intEnable,
  output logic       ready,
  output logic       calFail
);
  localparam int WinMax = (MONO_WIN > WIN) ? MONO_WIN : WIN;
  localparam int WCNT_W = $clog2(WinMax + 1);
  localparam int ITER_W = $clog2(MAX_ITER + 1);

  calState_t         state;
  logic [WCNT_W-1:0] winCnt, winLen;
  logic [ITER_W-1:0] iterQ;
  logic              monoQ, idleLike, startGo;

  always_comb begin
    idleLike  = (state == ST_IDLE) || (state == ST_DONE) || (state == ST_FAIL);
    startGo   = idleLike && startCal;
    winLen    = monoQ ? WCNT_W'(MONO_WIN) : WCNT_W'(WIN);
    intReset  = (state == ST_CLR);
    intEnable = (state == ST_INTEG);
    stb.load   = startGo;
    stb.update = (state == ST_SAMPLE);
    stb.mono   = idleLike ? monoMode : monoQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      winCnt  <= '0;
      iterQ   <= '0;
      monoQ   <= 1'b0;
      ready   <= 1'b0;
      calFail <= 1'b0;
    end else if (startGo) begin
      state   <= ST_CLR;
      monoQ   <= monoMode;
      iterQ   <= '0;
      ready   <= 1'b0;
      calFail <= 1'b0;
    end else begin
      unique case (state)
        ST_CLR: begin
          winCnt <= '0;
          state  <= ST_INTEG;
        end
        ST_INTEG: begin
          if (winCnt == winLen - WCNT_W'(1)) state <= ST_SAMPLE;
          else winCnt <= winCnt + WCNT_W'(1);
        end
        ST_SAMPLE: begin
          if (converged) begin
            state <= ST_DONE;
            ready <= 1'b1;
          end else if (iterQ == ITER_W'(MAX_ITER - 1)) begin
            state   <= ST_FAIL;
            calFail <= 1'b1;
          end else begin
            iterQ <= iterQ + ITER_W'(1);
            state <= ST_CLR;
          end
        end
        default: ;
      endcase
    end
  end

  // R1: integrator reset and integrate window never overlap
  p_no_overlap_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(intReset && intEnable));
  // R1: every window opens straight after an integrator reset
  p_win_after_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intEnable) |-> $past(intReset));
  // R2: window counter stays inside the selected length
  p_win_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    intEnable |-> winCnt < winLen);
  // R7: outcomes are exclusive
  p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(ready && calFail));
  // R7: iteration counter stays below the limit
  p_iter_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    iterQ < ITER_W'(MAX_ITER));
  // R9: a start pulse mid-run does not restart the sequence
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rstN)
    (startCal && intEnable && winCnt != '0) |=> !intReset);
endmodule

// File: rtl/timer_cal_seq.sv
module timer_cal_seq
  import tcal_pkg::*;
#(
  parameter int CODE_W   = 6,
  parameter int WIN      = 8,
  parameter int MONO_WIN = 24,
  parameter int MAX_ITER = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startCal,
  input  logic              monoMode,
  input  logic              cmpHigh,
  output logic              intReset,
  output logic              intEnable,
  output logic [CODE_W-1:0] ctrlCode,
  output logic [CODE_W-1:0] slaveCode,
  output logic              ready,
  output logic              calFail
);
  calStrobe_t stb;
  logic       converged;

  tcal_ctrl #(.WIN(WIN), .MONO_WIN(MONO_WIN), .MAX_ITER(MAX_ITER)) ctrl_i (
    .clk(clk), .rstN(rstN), .startCal(startCal), .monoMode(monoMode),
    .converged(converged), .stb(stb), .intReset(intReset),
    .intEnable(intEnable), .ready(ready), .calFail(calFail)
  );

  tcal_datapath #(.CODE_W(CODE_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .cmpHigh(cmpHigh),
    .code(ctrlCode), .slaveCode(slaveCode), .converged(converged)
  );
endmodule

// File: tb/timer_cal_seq_tb_top.sv
module timer_cal_seq_tb_top;
  localparam int CODE_W = 6, WIN = 8, MONO_WIN = 24, MAX_ITER = 16;
  localparam int MAXC = (1 << CODE_W) - 1;

  logic clk = 1'b0, rstN = 1'b0, startCal = 1'b0, monoMode = 1'b0, cmpHigh = 1'b0;
  logic intReset, intEnable, ready, calFail;
  logic [CODE_W-1:0] ctrlCode, slaveCode;

  int checks = 0, failures = 0, cycles = 0;
  int pulses, codeAt2, badWin, curWin;

  always #10 clk = ~clk;  // 50 MHz

  timer_cal_seq #(.CODE_W(CODE_W), .WIN(WIN), .MONO_WIN(MONO_WIN), .MAX_ITER(MAX_ITER)) dut_i (
    .clk(clk), .rstN(rstN), .startCal(startCal), .monoMode(monoMode), .cmpHigh(cmpHigh),
    .intReset(intReset), .intEnable(intEnable), .ctrlCode(ctrlCode),
    .slaveCode(slaveCode), .ready(ready), .calFail(calFail)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic void model(input int target, output int fcode, output bit rdy,
                                output int iters, output int code1);
    int code = 1 << (CODE_W-1);
    int step = 1 << (CODE_W-2);
    bit havePrev = 0, prevUp = 0;
    rdy = 0; iters = 0; code1 = code;
    for (int i = 1; i <= MAX_ITER; i++) begin
      bit up = !(code > target);
      iters = i;
      if (havePrev && up != prevUp && step == 1) begin rdy = 1; break; end
      if (havePrev && up != prevUp) step = step / 2;
      code = up ? ((code + step > MAXC) ? MAXC : code + step)
                : ((code < step) ? 0 : code - step);
      prevUp = up; havePrev = 1;
      if (i == 1) code1 = code;
    end
    fcode = code;
  endfunction

  task automatic runCal(input int target, input bit mono, input bit midStart);
    bit midDone = 0;
    int guard = 0;
    pulses = 0; codeAt2 = -1; badWin = 0; curWin = 0;
    @(negedge clk); startCal = 1'b1; monoMode = mono;
    @(negedge clk); startCal = 1'b0;
    while (guard < 3000) begin
      cmpHigh = (int'(ctrlCode) > target);
      if (intReset && intEnable) badWin++;
      if (intReset) begin
        pulses++;
        if (pulses == 2) codeAt2 = int'(ctrlCode);
      end
      if (intEnable) curWin++;
      else if (curWin != 0) begin
        if (curWin != (mono ? MONO_WIN : WIN)) badWin++;
        curWin = 0;
      end
      if (midStart && !midDone && pulses == 3 && intEnable) begin
        startCal = 1'b1; midDone = 1;
      end else startCal = 1'b0;
      if (ready || calFail) break;
      guard++;
      @(negedge clk);
    end
    startCal = 1'b0;
  endtask

  task automatic checkRun(input int target, input bit mono, input string tag);
    int fcode, iters, code1; bit rdy;
    model(target, fcode, rdy, iters, code1);
    chk(badWin == 0, mono ? "R2 window length" : "R1 window length", badWin, 0);
    chk(ready == rdy, "R6 ready", ready, rdy);
    chk(calFail == !rdy, "R7 calFail", calFail, !rdy);
    chk(int'(ctrlCode) == fcode, {tag, " final code"}, ctrlCode, fcode);
    chk(pulses == iters, "R7 iteration count", pulses, iters);
    if (iters >= 2) chk(codeAt2 == code1, "R3 first update direction", codeAt2, code1);
  endtask

  initial begin
    int prevSlave;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(ctrlCode == 6'd32, "R10 ctrlCode", ctrlCode, 32);
    chk(slaveCode == 6'd32, "R10 slaveCode", slaveCode, 32);
    chk(!ready && !calFail, "R10 flags", {ready, calFail}, 0);
    chk(!intEnable && !intReset, "R10 integrator controls", {intEnable, intReset}, 0);

    // R3 R4 R5 R6 R7 R8: sweep every target in timer mode
    for (int t = 0; t <= MAXC; t++) begin
      runCal(t, 1'b0, 1'b0);
      checkRun(t, 1'b0, (t == 0 || t == MAXC) ? "R5" : "R4");
      chk(slaveCode == ctrlCode, "R8 slave follows", slaveCode, ctrlCode);
    end

    // R9: start pulse mid-run is ignored
    runCal(20, 1'b0, 1'b1);
    checkRun(20, 1'b0, "R9");

    // R2 R8: slow-ramp mode leaves slave untouched
    runCal(41, 1'b0, 1'b0);
    prevSlave = int'(slaveCode);
    runCal(10, 1'b1, 1'b0);
    checkRun(10, 1'b1, "R2");
    chk(int'(slaveCode) == prevSlave, "R8 slave held in mono", slaveCode, prevSlave);
    runCal(55, 1'b1, 1'b0);
    checkRun(55, 1'b1, "R2");
    chk(int'(slaveCode) == prevSlave, "R8 slave held in mono", slaveCode, prevSlave);

    // R6: ready holds while idle
    repeat (5) @(negedge clk);
    chk(ready == 1'b1, "R6 ready held", ready, 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule